// File: doc/BRIEF.md
# Serial Peripheral Master Shift Engine with Word Queues

This block drives a four-wire serial peripheral bus as its only master. The host loads outgoing words into a 16-entry transmit queue through a small register port, fires a start command, and collects incoming words from a 16-entry receive queue. Each transmit entry has a flag that ends the transfer. When the flagged word has left the wire, the engine returns to idle and reports completion. The serial clock runs at half the rate of an external bit strobe `sclk_tick`: one phase per strobe.

Nine sticky events record completion, queue levels, queue overflow and underflow, and a transmit starvation. The host clears an event by writing a 1 to its bit. A mask register selects which pending events reach `irq`. When the transmit queue runs dry in the middle of a transfer, the engine raises an event and holds the bus. A new start command resumes the transfer from the next queued word. A loopback option feeds the outgoing bit back into the receiver, which allows a self-test without a peripheral attached.

Register map, selected by `host_addr`:
- 0 is configuration.
- 1 is command.
- 2 is status.
- 3 is events.
- 4 is mask.
- 5 is the data window. A write pushes a transmit entry. A read pops a receive entry.

All reads are combinational. All writes take effect at the clock edge where `host_wr` is high.

The serial engine moves through five named states:
- IDLE waits for start while ready.
- LOAD pops the next word. It goes to LOW when a word is present and to PAUSE when the queue is empty.
- LOW holds the clock low with the bit on `mosi` and samples the input bit on the next strobe, entering HIGH.
- HIGH holds the clock high. On the next strobe it shifts to the next bit and returns to LOW. After the final bit it stores the received word and goes to LOAD, or to IDLE if the word was flagged.
- PAUSE waits for a repeated start and then goes to LOAD.

Clearing the enable bit sends every state to IDLE.

Top module: `spi_fifo_master`

## Requirements
- R1: The bit count per word is configuration[4:0]. Values below 4 act as 4 and values above 24 act as 24. A received word read from the data window is zero above the bit count.
- R2: With configuration[5]=0 the most significant bit of the word goes out first; with configuration[5]=1 the least significant bit goes first. Bits change while `sclk` is low, and the input is sampled on the rising edge of `sclk`.
- R3: Bit 24 of a data window write marks the entry as the last of its transfer. When that word completes, event bit 0 (done) is set and the engine goes idle with `sclk` low.
- R4: A transfer begins only on a command write with bit 0 set while ready. Queued words are not shifted without it, so status[1] (busy) stays 0 and no word is received.
- R5: The event bits are:
  - 0: done
  - 1: slave done (never set)
  - 2: multi-master error (never set)
  - 3: receive request
  - 4: receive overflow
  - 5: receive underflow
  - 6: transmit request
  - 7: transmit overflow
  - 8: transmit underflow

  Writing 1 to an event bit clears it. A new set in the same cycle wins. Reset clears all events.
- R6: Mask bit k set blocks event k from `irq`. The mask resets to all ones. `irq` is high when any unmasked event is pending.
- R7: If LOAD finds the transmit queue empty, event bit 8 is set and the engine pauses, still busy, with `sclk` low. A later start resumes with the next queued word.
- R8: Command bit 1 flushes the receive queue and command bit 2 flushes the transmit queue. The matching command bit reads 1 for the one cycle until the flush takes place, and reads 0 afterwards.
- R9: Status[0] (ready) reads 0 until 4 clock edges after configuration[7] (enable) is set. A start issued while not ready is ignored.
- R10: Configuration[9:8] selects a level:
  - 00 selects 1.
  - 01 selects 4.
  - 10 selects 8.
  - 11 selects 12.

  Event 3 is set while the receive queue holds at least that many words. Event 6 is set while the transmit queue has at least that many free entries.
- R11: Configuration[6] routes `mosi` back to the receiver in place of `miso`.
- R12: Each queue holds 16 words. Status[2] reports transmit full and status[3] reports receive empty. A data write while full is dropped and sets event 7. A data read while empty returns 0 and sets event 5. A received word arriving at a full receive queue is dropped and sets event 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe; pops the receive queue at address 5 |
| host_addr | input | 3 | Register select |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, combinational from `host_addr` |
| sclk_tick | input | 1 | Bit-phase strobe; each pulse advances the serial clock half a period |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | OR of unmasked pending events |

## Verification
The results fall due at different times:
- Register reads show state in the same cycle.
- A write changes state at the next edge.
- A flush command is visible on the command register one cycle before the queue empties.
- Ready follows enable by exactly four edges.

The bench drives each register access at the falling clock edge and samples one nanosecond later, so every value it reads was set by an earlier rising edge. Serial progress depends on the strobe rate, so the bench does not count a fixed number of cycles for a transfer. It polls the event register until the done or underflow bit appears, and only then reads the received data and status.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int NUM_EV   = 9;
    localparam int EV_MDONE = 0;
    localparam int EV_SDONE = 1;
    localparam int EV_MMERR = 2;
    localparam int EV_RXREQ = 3;
    localparam int EV_RXOVF = 4;
    localparam int EV_RXUNF = 5;
    localparam int EV_TXREQ = 6;
    localparam int EV_TXOVF = 7;
    localparam int EV_TXUNF = 8;

    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_CMD  = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_EVT  = 3'd3;
    localparam logic [2:0] A_MASK = 3'd4;
    localparam logic [2:0] A_DATA = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_PAUSE
    } shift_state_t;

    function automatic int thr_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 12;
        endcase
    endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 25,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int MAXW = 24,
    localparam int LW  = $clog2(MAXW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            ready,
    input  logic            tick,
    input  logic            start,
    input  logic [LW-1:0]   len,
    input  logic            lsb_first,
    input  logic            loopback,
    input  logic            miso,
    input  logic            tx_valid,
    input  logic [MAXW-1:0] tx_word,
    input  logic            tx_last,
    output logic            tx_pop,
    output logic            rx_push,
    output logic [MAXW-1:0] rx_word,
    output logic            done,
    output logic            uflow,
    output logic            sclk,
    output logic            mosi,
    output logic            busy
);
    localparam logic [MAXW-1:0] ONE = MAXW'(1);

    shift_state_t    state_q, state_d;
    logic [MAXW-1:0] sh_q, rx_q, len_mask;
    logic [LW-1:0]   cnt_q, top_idx;
    logic            last_q, cur_bit, din, word_end;

    assign top_idx  = len - 1'b1;
    assign cur_bit  = lsb_first ? sh_q[0] : sh_q[top_idx];
    assign din      = loopback ? mosi : miso;
    assign word_end = (cnt_q == '0);
    assign len_mask = (ONE << len) - ONE;
    assign rx_word  = rx_q & len_mask;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && ready) state_d = ST_LOAD;
            ST_LOAD:  state_d = tx_valid ? ST_LOW : ST_PAUSE;
            ST_LOW:   if (tick) state_d = ST_HIGH;
            ST_HIGH:  if (tick) state_d = word_end ? (last_q ? ST_IDLE : ST_LOAD) : ST_LOW;
            ST_PAUSE: if (start) state_d = ST_LOAD;
            default:  state_d = ST_IDLE;
        endcase
        if (!en) state_d = ST_IDLE;
    end

    // outputs
    always_comb begin
        sclk    = 1'b0;
        mosi    = 1'b0;
        tx_pop  = 1'b0;
        uflow   = 1'b0;
        rx_push = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_LOAD: begin
                tx_pop = tx_valid;
                uflow  = !tx_valid;
            end
            ST_LOW:   mosi = cur_bit;
            ST_HIGH: begin
                sclk    = 1'b1;
                mosi    = cur_bit;
                rx_push = tick && word_end;
                done    = tick && word_end && last_q;
            end
            ST_PAUSE: busy = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rx_q   <= '0;
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else begin
            case (state_q)
                ST_LOAD: if (tx_valid) begin
                    sh_q   <= tx_word;
                    last_q <= tx_last;
                    cnt_q  <= top_idx;
                    rx_q   <= '0;
                end
                ST_LOW: if (tick) begin
                    rx_q <= lsb_first ? ((rx_q >> 1) | ({MAXW{din}} & (ONE << top_idx)))
                                      : {rx_q[MAXW-2:0], din};
                end
                ST_HIGH: if (tick && !word_end) begin
                    sh_q  <= lsb_first ? (sh_q >> 1) : (sh_q << 1);
                    cnt_q <= cnt_q - 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int MAXW      = 24,
    parameter int DEPTH     = 16,
    parameter int READY_DLY = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        sclk_tick,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        irq
);
    localparam int LW  = $clog2(MAXW + 1);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int RDW = $clog2(READY_DLY + 1);

    // configuration
    logic [LW-1:0]     cfg_len, len_eff;
    logic              cfg_lsb, cfg_loop, cfg_en;
    logic [1:0]        cfg_thr;
    logic [NUM_EV-1:0] ev_q, mask_q, ev_set, ev_clr;
    logic              rx_fl_q, tx_fl_q;
    logic [RDW-1:0]    rdy_cnt;
    logic              ready;

    // host decode
    logic wr_cfg, wr_cmd, wr_evt, wr_mask, wr_data, rd_data, start;
    assign wr_cfg  = host_wr && (host_addr == A_CFG);
    assign wr_cmd  = host_wr && (host_addr == A_CMD);
    assign wr_evt  = host_wr && (host_addr == A_EVT);
    assign wr_mask = host_wr && (host_addr == A_MASK);
    assign wr_data = host_wr && (host_addr == A_DATA);
    assign rd_data = host_rd && (host_addr == A_DATA);
    assign start   = wr_cmd && host_wdata[0];

    // queues and engine
    logic [MAXW:0]   tx_dout;
    logic [MAXW-1:0] rx_dout, rx_word;
    logic [CW-1:0]   tx_count, rx_count, thr;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic            tx_pop, rx_push, sh_done, sh_uflow, busy;

    assign len_eff = (cfg_len < LW'(4))    ? LW'(4)
                   : (cfg_len > LW'(MAXW)) ? LW'(MAXW) : cfg_len;
    assign thr     = CW'(thr_level(cfg_thr));

    spim_fifo #(.W(MAXW + 1), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_fl_q),
        .push  (wr_data),
        .din   ({host_wdata[24], host_wdata[MAXW-1:0]}),
        .pop   (tx_pop),
        .dout  (tx_dout),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spim_fifo #(.W(MAXW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_fl_q),
        .push  (rx_push),
        .din   (rx_word),
        .pop   (rd_data),
        .dout  (rx_dout),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spim_shifter #(.MAXW(MAXW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .ready     (ready),
        .tick      (sclk_tick),
        .start     (start),
        .len       (len_eff),
        .lsb_first (cfg_lsb),
        .loopback  (cfg_loop),
        .miso      (miso),
        .tx_valid  (!tx_empty),
        .tx_word   (tx_dout[MAXW-1:0]),
        .tx_last   (tx_dout[MAXW]),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .rx_word   (rx_word),
        .done      (sh_done),
        .uflow     (sh_uflow),
        .sclk      (sclk),
        .mosi      (mosi),
        .busy      (busy)
    );

    // enable-to-ready delay
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            rdy_cnt <= '0;
        else if (!cfg_en)                      rdy_cnt <= '0;
        else if (rdy_cnt != RDW'(READY_DLY))   rdy_cnt <= rdy_cnt + 1'b1;
    end
    assign ready = (rdy_cnt == RDW'(READY_DLY));

    // registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_len  <= LW'(8);
            cfg_lsb  <= 1'b0;
            cfg_loop <= 1'b0;
            cfg_en   <= 1'b0;
            cfg_thr  <= 2'b00;
            mask_q   <= '1;
            rx_fl_q  <= 1'b0;
            tx_fl_q  <= 1'b0;
        end else begin
            if (wr_cfg) begin
                cfg_len  <= host_wdata[LW-1:0];
                cfg_lsb  <= host_wdata[5];
                cfg_loop <= host_wdata[6];
                cfg_en   <= host_wdata[7];
                cfg_thr  <= host_wdata[9:8];
            end
            if (wr_mask) mask_q <= host_wdata[NUM_EV-1:0];
            rx_fl_q <= wr_cmd && host_wdata[1];
            tx_fl_q <= wr_cmd && host_wdata[2];
        end
    end

    // events
    always_comb begin
        ev_set           = '0;
        ev_set[EV_MDONE] = sh_done;
        ev_set[EV_RXREQ] = (rx_count >= thr);
        ev_set[EV_RXOVF] = rx_push && rx_full;
        ev_set[EV_RXUNF] = rd_data && rx_empty;
        ev_set[EV_TXREQ] = ((CW'(DEPTH) - tx_count) >= thr);
        ev_set[EV_TXOVF] = wr_data && tx_full;
        ev_set[EV_TXUNF] = sh_uflow;
        ev_clr           = wr_evt ? host_wdata[NUM_EV-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (ev_q & ~ev_clr) | ev_set;
    end

    assign irq = |(ev_q & ~mask_q);

    // read mux
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_CFG:  host_rdata = {22'd0, cfg_thr, cfg_en, cfg_loop, cfg_lsb, 5'(cfg_len)};
            A_CMD:  host_rdata = {29'd0, tx_fl_q, rx_fl_q, 1'b0};
            A_STAT: host_rdata = {28'd0, rx_empty, tx_full, busy, ready};
            A_EVT:  host_rdata = 32'(ev_q);
            A_MASK: host_rdata = 32'(mask_q);
            A_DATA: host_rdata = rx_empty ? 32'd0 : 32'(rx_dout);
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          ready,
    input logic          sclk,
    input logic          sh_done,
    input logic          sh_uflow,
    input logic [8:0]    ev_q,
    input logic          wr_evt,
    input logic [31:0]   host_wdata,
    input logic          wr_data,
    input logic          tx_full,
    input logic          tx_pop,
    input logic          tx_fl_q,
    input logic [CW-1:0] tx_count,
    input logic          rx_fl_q,
    input logic [CW-1:0] rx_count
);
    AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ready)); // R4

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk); // R3

    AST_DONE_SETS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |=> ev_q[0]); // R3

    AST_EVENT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && host_wdata[0] && !sh_done) |=> !ev_q[0]); // R5

    AST_UFLOW_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        sh_uflow |=> (busy && !sclk && ev_q[8])); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_full && !tx_pop && !tx_fl_q) |=> (tx_count == $past(tx_count))); // R12

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fl_q |=> (rx_count == '0)); // R8
endmodule

bind spi_fifo_master spim_checker #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .ready      (ready),
    .sclk       (sclk),
    .sh_done    (sh_done),
    .sh_uflow   (sh_uflow),
    .ev_q       (ev_q),
    .wr_evt     (wr_evt),
    .host_wdata (host_wdata),
    .wr_data    (wr_data),
    .tx_full    (tx_full),
    .tx_pop     (tx_pop),
    .tx_fl_q    (tx_fl_q),
    .tx_count   (tx_count),
    .rx_fl_q    (rx_fl_q),
    .rx_count   (rx_count)
);

// File: tb/sim_spi_fifo_master.sv
module sim_spi_fifo_master;
    localparam logic [2:0] CFG = 3'd0, CMD = 3'd1, STAT = 3'd2,
                           EVT = 3'd3, MSK = 3'd4, DAT = 3'd5;

    typedef struct packed {
        logic [4:0]  len;
        logic        lsb;
        logic [23:0] data;
        logic [23:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{5'd8,  1'b0, 24'h0000A5, 24'h0000A5},
        '{5'd8,  1'b1, 24'h0000A5, 24'h0000A5},
        '{5'd4,  1'b0, 24'hFFFFF6, 24'h000006},
        '{5'd24, 1'b0, 24'h123456, 24'h123456},
        '{5'd24, 1'b1, 24'h800001, 24'h800001},
        '{5'd12, 1'b1, 24'hF00ABC, 24'h000ABC},
        '{5'd16, 1'b0, 24'hFF1234, 24'h001234},
        '{5'd5,  1'b1, 24'h000013, 24'h000013}
    };

    logic        clk = 0, rst_n = 0;
    logic        host_wr = 0, host_rd = 0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        sclk_tick = 0, sclk, mosi, miso = 0, irq;
    logic [23:0] cap = '0;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    spi_fifo_master u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sclk_tick(sclk_tick), .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
    );

    initial forever begin
        @(negedge clk);
        sclk_tick = ~sclk_tick;
    end

    initial forever begin
        @(posedge sclk);
        #1 cap = {cap[22:0], mosi};
    end

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL R3 watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1;
        @(posedge clk);
        #1 host_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1;
        #1 d = host_rdata;
        @(posedge clk);
        #1 host_rd = 0;
    endtask

    task automatic wait_ev(input int b, input string req);
        logic [31:0] d;
        logic seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            rd(EVT, d);
            seen = d[b];
        end
        chk(req, 32'(seen), 32'd1);
    endtask

    function automatic logic [23:0] rev(input logic [23:0] d, input int n);
        logic [23:0] r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = d[i];
        return r;
    endfunction

    function automatic logic [31:0] cfgw(input logic [4:0] len, input logic lsb, input logic lb);
        return {22'd0, 2'b10, 1'b1, lb, lsb, len};
    endfunction

    logic [31:0] d;

    initial begin
        // reset state
        repeat (2) @(negedge clk);
        rd(EVT, d);  chk("R5 reset events", d, 32'h0);
        rd(MSK, d);  chk("R6 reset mask", d, 32'h1FF);
        rd(STAT, d); chk("R12 reset status", d, 32'h8);
        chk("R6 reset irq", 32'(irq), 32'd0);
        @(negedge clk); rst_n = 1;
        repeat (2) @(negedge clk);
        rd(EVT, d);  chk("R10 tx request at level 1", d, 32'h040);

        // ready delay
        wr(CFG, cfgw(5'd8, 1'b0, 1'b1));
        rd(STAT, d); chk("R9 not ready yet", 32'(d[0]), 32'd0);
        repeat (6) @(negedge clk);
        rd(STAT, d); chk("R9 ready", 32'(d[0]), 32'd1);

        // no start, no shifting
        wr(EVT, 32'h1FF);
        wr(DAT, {7'd0, 1'b1, 24'h5A});
        repeat (40) @(negedge clk);
        rd(STAT, d); chk("R4 idle without start", d & 32'hA, 32'h8);
        wr(CMD, 32'h1);
        wait_ev(0, "R4 done after start");
        rd(DAT, d);  chk("R4 word after start", d, 32'h5A);

        // vector table, loopback
        for (int v = 0; v < NV; v++) begin
            wr(CFG, cfgw(VECS[v].len, VECS[v].lsb, 1'b1));
            wr(EVT, 32'h1FF);
            cap = '0;
            wr(DAT, {7'd0, 1'b1, VECS[v].data});
            wr(CMD, 32'h1);
            wait_ev(0, "R3 done event");
            rd(DAT, d);
            chk("R1 R11 loopback word", d, 32'(VECS[v].exp));
            chk("R2 wire bit order", 32'(cap),
                VECS[v].lsb ? 32'(rev(VECS[v].exp, int'(VECS[v].len))) : 32'(VECS[v].exp));
        end
        rd(STAT, d); chk("R3 idle after last", 32'(d[1]), 32'd0);

        // external input, loopback off
        miso = 1;
        wr(CFG, cfgw(5'd6, 1'b0, 1'b0));
        wr(EVT, 32'h1FF);
        wr(DAT, {7'd0, 1'b1, 24'h000000});
        wr(CMD, 32'h1);
        wait_ev(0, "R11 done");
        rd(DAT, d); chk("R11 R1 miso ones masked", d, 32'h3F);
        miso = 0;

        // underflow pause and resume
        wr(CFG, cfgw(5'd8, 1'b0, 1'b1));
        wr(EVT, 32'h1FF);
        wr(DAT, {7'd0, 1'b0, 24'h11});
        wr(CMD, 32'h1);
        wait_ev(8, "R7 underflow event");
        rd(STAT, d); chk("R7 paused busy", d & 32'hA, 32'h2);
        chk("R7 sclk low in pause", 32'(sclk), 32'd0);
        wr(DAT, {7'd0, 1'b1, 24'h22});
        wr(CMD, 32'h1);
        wait_ev(0, "R7 resume done");
        rd(DAT, d); chk("R7 first word", d, 32'h11);
        rd(DAT, d); chk("R7 second word", d, 32'h22);

        // irq masking
        wr(MSK, 32'h1FE);
        #1 chk("R6 irq unmasked", 32'(irq), 32'd1);
        wr(MSK, 32'h1FF);
        #1 chk("R6 irq masked", 32'(irq), 32'd0);

        // write-one-to-clear
        wr(EVT, 32'h1);
        rd(EVT, d); chk("R5 done cleared", 32'(d[0]), 32'd0);

        // overflow, depth, receive level, underflow read
        wr(EVT, 32'h1FF);
        for (int i = 1; i < 16; i++) wr(DAT, 32'(i));
        wr(DAT, {7'd0, 1'b1, 24'h10});
        rd(STAT, d); chk("R12 tx full", 32'(d[2]), 32'd1);
        wr(DAT, {7'd0, 1'b1, 24'hEE});
        rd(EVT, d); chk("R12 tx overflow event", 32'(d[7]), 32'd1);
        wr(CMD, 32'h1);
        wait_ev(0, "R12 done 16 words");
        rd(EVT, d); chk("R10 rx request at 8", 32'(d[3]), 32'd1);
        for (int i = 0; i < 9; i++) rd(DAT, d);
        wr(EVT, 32'h8);
        rd(EVT, d); chk("R10 rx request below 8", 32'(d[3]), 32'd0);
        for (int i = 0; i < 6; i++) rd(DAT, d);
        rd(DAT, d); chk("R12 last kept word", d, 32'h10);
        rd(STAT, d); chk("R12 rx empty", 32'(d[3]), 32'd1);
        rd(DAT, d); chk("R12 empty read zero", d, 32'h0);
        rd(EVT, d); chk("R12 rx underflow event", 32'(d[5]), 32'd1);

        // transmit flush
        wr(DAT, 32'h77); wr(DAT, 32'h78);
        wr(CMD, 32'h4);
        rd(CMD, d); chk("R8 tx flush pending", 32'(d[2]), 32'd1);
        rd(CMD, d); chk("R8 tx flush done", 32'(d[2]), 32'd0);
        wr(EVT, 32'h1FF);
        wr(DAT, {7'd0, 1'b1, 24'h42});
        wr(CMD, 32'h1);
        wait_ev(0, "R8 done after flush");
        rd(DAT, d);  chk("R8 only new word", d, 32'h42);
        rd(STAT, d); chk("R8 nothing else", 32'(d[3]), 32'd1);

        // receive flush
        wr(EVT, 32'h1FF);
        wr(DAT, {7'd0, 1'b1, 24'h33});
        wr(CMD, 32'h1);
        wait_ev(0, "R8 done before rx flush");
        rd(STAT, d); chk("R8 rx holds word", 32'(d[3]), 32'd0);
        wr(CMD, 32'h2);
        rd(CMD, d); chk("R8 rx flush pending", 32'(d[1]), 32'd1);
        rd(CMD, d); chk("R8 rx flush done", 32'(d[1]), 32'd0);
        rd(STAT, d); chk("R8 rx empty after flush", 32'(d[3]), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule